// File: doc/BRIEF.md
# Flash Status-Polling Verifier

This block runs on the host side of a parallel flash interface and decides whether a program or erase operation has finished, and whether it worked. A start pulse supplies the address to poll, the byte that was written and a mode flag that selects erase or program. The block then issues reads to that address over a request/acknowledge port. In each returned byte it looks at two status bits: the polling bit, which reads as the true value of the written datum once the operation is finished, and the time-limit bit, which the flash raises when its internal operation has run too long.

The polling bit is compared with its expected value. In erase mode that value is always 1, because erased cells read as ones. If it does not match and the time-limit bit is low, the block polls again. If the time-limit bit is high, the block does not give up at once. The two bits can flip in the same read, so one more read decides the result. On a match, one further confirming read is made, and its byte is reported as the trusted result. The polling bit can settle before the other data bits do, so the byte that showed the match is not used. A cycle limit ends with a failure any operation that never concludes, for example on a bus that never acknowledges.

For an erase, the address must lie inside a sector chosen for erasure. For a whole-device erase, any address in an unprotected sector will do.

Top module: `dpoll_checker`

## Requirements
- R1: After reset the block is idle: busy_o, rd_req_o, done_o, pass_o and fail_o are all 0.
- R2: A start_i seen while idle captures start_addr_i. rd_addr_o carries that address for every read of the operation. rd_req_o rises in the cycle after start_i and stays high until the cycle in which rd_ack_i is 1.
- R3: The expected value of bit 7 (the polling bit) is bit 7 of start_data_i when start_erase_i is 0, and is 1 when start_erase_i is 1.
- R4: A poll read whose bit 7 equals the expected value is followed by exactly one confirming read, and the operation then ends in pass.
- R5: A poll read whose bit 7 differs from the expected value and whose bit 5 (the time-limit bit) is 0 is followed by another poll read.
- R6: A poll read whose bit 7 differs and whose bit 5 is 1 is followed by exactly one recheck read. If that read matches bit 7, a confirming read follows and the result is pass. If it does not match, the result is fail and no further read is issued.
- R7: On pass, result_o holds the full byte returned by the confirming read. It does not hold the byte from the poll read that matched.
- R8: done_o is a one-cycle pulse in the cycle after the final acknowledge. It is accompanied by exactly one of pass_o or fail_o, and busy_o is 0 in that cycle.
- R9: A start_i that arrives while busy_o is 1 has no effect. The address, the outcome and the number of reads are those of the operation already running.
- R10: If an operation has not concluded after LIMIT_CYC busy cycles, it ends with done_o and fail_o, rd_req_o drops, and busy_o has been high for exactly LIMIT_CYC cycles.
- R11: A new read is issued only after the previous read has been acknowledged. Once done_o has pulsed, rd_req_o stays 0 until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a verification (accepted only when idle) |
| start_addr_i | input | ADDR_W | Address to poll |
| start_data_i | input | DATA_W | Byte that was programmed |
| start_erase_i | input | 1 | 1 = erase verification, 0 = program verification |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | ADDR_W | Read address |
| rd_ack_i | input | 1 | Read acknowledge, one cycle, data valid with it |
| rd_data_i | input | DATA_W | Read data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Operation succeeded (with done_o) |
| fail_o | output | 1 | Operation failed (with done_o) |
| result_o | output | DATA_W | Byte from the confirming read after pass |

## Verification
The bench targets several corner cases. In one, the time-limit bit rises together with a still-wrong polling bit and the recheck then matches. A design that stops at the first time-limit indication would report fail there. In another, the time-limit bit and a mismatch are followed by a mismatching recheck. A design that keeps polling would issue an extra read there. In the erase case the written byte has bit 7 clear. A design that compares against the datum instead of 1 would pass at once. The confirming read returns a byte different from the matching poll byte, which exposes a design that reports the wrong byte. Two further cases cover a start pulse given mid-operation, which must not move the address, and a bus that never acknowledges, which must end in fail after exactly the cycle limit.

// File: rtl/dpoll_pkg.sv
package dpoll_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_POLL    = 2'd1,
      ST_RECHECK = 2'd2,
      ST_CONFIRM = 2'd3
   } dpoll_state_e;

   typedef enum logic [1:0] {
      OUT_NONE = 2'd0,
      OUT_PASS = 2'd1,
      OUT_FAIL = 2'd2
   } dpoll_outcome_e;

endpackage

// File: rtl/dpoll_eval.sv
module dpoll_eval #(
   parameter int DATA_W   = 8,
   parameter int POLL_BIT = 7,
   parameter int TOUT_BIT = 5
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic              exp_bit_i,
   output logic              match_o,
   output logic              tout_o
);

   if (POLL_BIT >= DATA_W) begin : g_bad_poll
      $error("dpoll_eval: POLL_BIT outside data word");
   end
   if (TOUT_BIT >= DATA_W) begin : g_bad_tout
      $error("dpoll_eval: TOUT_BIT outside data word");
   end
   if (TOUT_BIT == POLL_BIT) begin : g_bad_same
      $error("dpoll_eval: status bits must differ");
   end

   always_comb begin
      match_o = (data_i[POLL_BIT] == exp_bit_i);
      tout_o  = data_i[TOUT_BIT];
   end

endmodule

// File: rtl/dpoll_limit.sv
module dpoll_limit #(
   parameter int LIMIT_CYC = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic expired_o
);

   if (LIMIT_CYC < 0) begin : g_bad_limit
      $error("dpoll_limit: LIMIT_CYC must not be negative");
   end

   if (LIMIT_CYC == 0) begin : g_off
      assign expired_o = 1'b0;
   end else begin : g_on
      localparam int CNT_W = (LIMIT_CYC < 2) ? 1 : $clog2(LIMIT_CYC);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT_CYC - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n || !run_i) begin
            cnt_q <= '0;
         end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      assign expired_o = run_i && (cnt_q == LAST);

      a_r10_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q <= LAST);
   end

endmodule

// File: rtl/dpoll_fsm.sv
module dpoll_fsm
   import dpoll_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic              start_exp_i,
   input  logic              rd_ack_i,
   input  logic [DATA_W-1:0] rd_data_i,
   input  logic              match_i,
   input  logic              tout_i,
   input  logic              expired_i,
   output logic              exp_bit_o,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              pass_o,
   output logic              fail_o,
   output logic [DATA_W-1:0] result_o
);

   dpoll_state_e   state_q, state_d;
   dpoll_outcome_e finish;
   logic [ADDR_W-1:0] addr_q;
   logic              exp_q;

   always_comb begin
      state_d = state_q;
      finish  = OUT_NONE;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) state_d = ST_POLL;
         end
         ST_POLL: begin
            if (rd_ack_i) begin
               if (match_i)     state_d = ST_CONFIRM;
               else if (tout_i) state_d = ST_RECHECK;
               else             state_d = ST_POLL;
            end
         end
         ST_RECHECK: begin
            if (rd_ack_i) begin
               if (match_i) begin
                  state_d = ST_CONFIRM;
               end else begin
                  state_d = ST_IDLE;
                  finish  = OUT_FAIL;
               end
            end
         end
         ST_CONFIRM: begin
            if (rd_ack_i) begin
               state_d = ST_IDLE;
               finish  = OUT_PASS;
            end
         end
         default: state_d = ST_IDLE;
      endcase
      if (expired_i && state_q != ST_IDLE) begin
         state_d = ST_IDLE;
         finish  = OUT_FAIL;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         addr_q   <= '0;
         exp_q    <= 1'b0;
         done_o   <= 1'b0;
         pass_o   <= 1'b0;
         fail_o   <= 1'b0;
         result_o <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && start_i) begin
            addr_q <= start_addr_i;
            exp_q  <= start_exp_i;
         end
         done_o <= (finish != OUT_NONE);
         pass_o <= (finish == OUT_PASS);
         fail_o <= (finish == OUT_FAIL);
         if (finish == OUT_PASS) result_o <= rd_data_i;
      end
   end

   assign exp_bit_o = exp_q;
   assign rd_addr_o = addr_q;
   assign busy_o    = (state_q != ST_IDLE);
   assign rd_req_o  = (state_q != ST_IDLE);

   // R8: outcome flags are exclusive and only with done
   a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $onehot({pass_o, fail_o}));
   a_r8_no_stray_flag: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> !pass_o && !fail_o);
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r8_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   // R2: request held until acknowledged (unless the limit fires)
   a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o && !rd_ack_i && !expired_i |=> rd_req_o);
   // R9: address cannot move during an operation
   a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && $past(busy_o) |-> $stable(rd_addr_o));
   // R11: no request right after completion
   a_r11_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !rd_req_o);
   // R6: a mismatching recheck always ends the operation in fail
   a_r6_recheck_final: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_RECHECK && rd_ack_i && !match_i |=> fail_o);

endmodule

// File: rtl/dpoll_checker.sv
module dpoll_checker #(
   parameter int ADDR_W    = 17,
   parameter int DATA_W    = 8,
   parameter int POLL_BIT  = 7,
   parameter int TOUT_BIT  = 5,
   parameter int LIMIT_CYC = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic [DATA_W-1:0] start_data_i,
   input  logic              start_erase_i,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic              rd_ack_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              pass_o,
   output logic              fail_o,
   output logic [DATA_W-1:0] result_o
);

   if (ADDR_W < 1) begin : g_bad_addr
      $error("dpoll_checker: ADDR_W must be positive");
   end

   logic start_exp;
   logic exp_bit;
   logic match;
   logic tout;
   logic expired;

   // R3: erase always expects the erased level on the polling bit
   assign start_exp = start_erase_i ? 1'b1 : start_data_i[POLL_BIT];

   dpoll_eval #(
      .DATA_W  (DATA_W),
      .POLL_BIT(POLL_BIT),
      .TOUT_BIT(TOUT_BIT)
   ) eval_i (
      .data_i   (rd_data_i),
      .exp_bit_i(exp_bit),
      .match_o  (match),
      .tout_o   (tout)
   );

   dpoll_limit #(
      .LIMIT_CYC(LIMIT_CYC)
   ) limit_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (busy_o),
      .expired_o(expired)
   );

   dpoll_fsm #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) fsm_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .start_addr_i(start_addr_i),
      .start_exp_i (start_exp),
      .rd_ack_i    (rd_ack_i),
      .rd_data_i   (rd_data_i),
      .match_i     (match),
      .tout_i      (tout),
      .expired_i   (expired),
      .exp_bit_o   (exp_bit),
      .rd_req_o    (rd_req_o),
      .rd_addr_o   (rd_addr_o),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .pass_o      (pass_o),
      .fail_o      (fail_o),
      .result_o    (result_o)
   );

   // R2: first request follows an accepted start
   a_r2_req_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o && start_i |=> rd_req_o && rd_addr_o == $past(start_addr_i));

endmodule

// File: tb/dpoll_checker_tb_top.sv
module dpoll_checker_tb_top;

   localparam int AW    = 17;
   localparam int DW    = 8;
   localparam int LIMIT = 512;
   localparam int NRESP = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [AW-1:0] start_addr_i = '0;
   logic [DW-1:0] start_data_i = '0;
   logic          start_erase_i = 1'b0;
   logic          rd_req_o;
   logic [AW-1:0] rd_addr_o;
   logic          rd_ack_i = 1'b0;
   logic [DW-1:0] rd_data_i = '0;
   logic          busy_o, done_o, pass_o, fail_o;
   logic [DW-1:0] result_o;

   int total = 0;
   int bad = 0;
   logic [DW-1:0] resp [NRESP];
   int      ridx = 0;
   bit      hang = 1'b0;
   logic [AW-1:0] cur_addr = '0;
   int      lat_max = 3;

   always #4 clk = ~clk;

   dpoll_checker #(.ADDR_W(AW), .DATA_W(DW), .LIMIT_CYC(LIMIT)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
      .start_data_i(start_data_i), .start_erase_i(start_erase_i),
      .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
      .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o),
      .fail_o(fail_o), .result_o(result_o));

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // bus responder: acknowledges each request after a random latency
   initial begin
      forever begin
         @(negedge clk);
         if (rd_req_o && !hang) begin
            check(rd_addr_o == cur_addr, "R2/R9 read address", rd_addr_o, cur_addr);
            repeat ($urandom % (lat_max + 1)) @(negedge clk);
            rd_ack_i  = 1'b1;
            rd_data_i = (ridx < NRESP) ? resp[ridx] : 8'h00;
            ridx++;
            @(negedge clk);
            rd_ack_i  = 1'b0;
            rd_data_i = $urandom;
         end
      end
   end

   // reference model straight from the requirements
   task automatic predict(input bit exp_bit, output bit pass, output logic [DW-1:0] res,
                          output int reads);
      int i = 0;
      pass = 0; res = '0; reads = 0;
      while (i < NRESP - 3) begin
         if (resp[i][7] == exp_bit) begin
            pass = 1; res = resp[i+1]; reads = i + 2; return;
         end else if (resp[i][5]) begin
            if (resp[i+1][7] == exp_bit) begin
               pass = 1; res = resp[i+2]; reads = i + 3;
            end else begin
               pass = 0; reads = i + 2;
            end
            return;
         end
         i++;
      end
   endtask

   task automatic run_op(input logic [AW-1:0] addr, input logic [DW-1:0] data,
                         input bit erase, input bit poke, input string tag);
      bit exp_pass; logic [DW-1:0] exp_res; int exp_reads;
      int wd = 0;
      predict(erase ? 1'b1 : data[7], exp_pass, exp_res, exp_reads);
      ridx = 0;
      cur_addr = addr;
      @(negedge clk);
      start_addr_i = addr; start_data_i = data; start_erase_i = erase; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check(rd_req_o == 1'b1, {tag, " R2 req after start"}, rd_req_o, 1);
      while (!done_o && wd < 4000) begin
         if (poke && wd == 2) begin
            start_addr_i = ~addr; start_data_i = ~data; start_erase_i = ~erase; start_i = 1'b1;
         end else begin
            start_i = 1'b0;
         end
         @(negedge clk);
         wd++;
      end
      start_i = 1'b0;
      check(wd < 4000, {tag, " watchdog"}, wd, 0);
      check(pass_o == exp_pass && fail_o == !exp_pass,
            {tag, " R4/R5/R6/R9 outcome"}, {pass_o, fail_o}, {exp_pass, !exp_pass});
      check(!busy_o, {tag, " R8 idle at done"}, busy_o, 0);
      if (exp_pass) check(result_o == exp_res, {tag, " R7 result byte"}, result_o, exp_res);
      @(negedge clk);
      check(!done_o && !pass_o && !fail_o, {tag, " R8 pulse width"}, done_o, 0);
      repeat (3) @(negedge clk);
      check(ridx == exp_reads, {tag, " R6/R11 read count"}, ridx, exp_reads);
      check(!rd_req_o, {tag, " R11 quiet after done"}, rd_req_o, 0);
   endtask

   initial begin
      void'($urandom(32'd7));
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!busy_o && !rd_req_o && !done_o && !pass_o && !fail_o, "R1 reset",
            {busy_o, rd_req_o, done_o, pass_o, fail_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 R7: immediate match, confirming byte differs
      foreach (resp[i]) resp[i] = 8'h00;
      resp[0] = 8'h80; resp[1] = 8'h5A;
      run_op(17'h00123, 8'hC3, 1'b0, 1'b0, "direct_match");

      // R3 R5 R6: erase with datum bit7 clear, timeout bit then match on recheck
      foreach (resp[i]) resp[i] = 8'h00;
      resp[0] = 8'h00; resp[1] = 8'h20; resp[2] = 8'h80; resp[3] = 8'hFF;
      run_op(17'h08000, 8'h00, 1'b1, 1'b0, "erase_recheck_pass");

      // R6: timeout bit, recheck mismatch -> fail, no further read
      foreach (resp[i]) resp[i] = 8'h80;
      resp[0] = 8'hA0; resp[1] = 8'h80;
      run_op(17'h18004, 8'h00, 1'b0, 1'b0, "recheck_fail");

      // R9: start pulse during an operation
      foreach (resp[i]) resp[i] = 8'h00;
      resp[3] = 8'h01; resp[4] = 8'h7E;
      run_op(17'h10010, 8'h01, 1'b0, 1'b1, "start_while_busy");

      // R10: bus never acknowledges
      begin
         int bcyc = 0;
         int wd = 0;
         hang = 1'b1;
         cur_addr = 17'h00042;
         @(negedge clk);
         start_addr_i = 17'h00042; start_data_i = 8'h80; start_erase_i = 1'b0; start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
         while (!done_o && wd < 4000) begin
            if (busy_o) bcyc++;
            @(negedge clk);
            wd++;
         end
         check(fail_o && !pass_o, "R10 limit fail", {pass_o, fail_o}, 2'b01);
         check(bcyc == LIMIT, "R10 busy cycles", bcyc, LIMIT);
         check(!rd_req_o, "R10 req dropped", rd_req_o, 0);
         hang = 1'b0;
         @(negedge clk);
      end

      // random operations
      for (int n = 0; n < 40; n++) begin
         bit er = ($urandom % 3) == 0;
         logic [DW-1:0] d = $urandom;
         bit eb = er ? 1'b1 : d[7];
         lat_max = $urandom % 5;
         foreach (resp[i]) begin
            resp[i] = $urandom;
            resp[i][7] = (($urandom % 4) == 0) ? eb : ~eb;
            resp[i][5] = (($urandom % 3) == 0);
         end
         resp[15][5] = 1'b1;
         run_op($urandom, d, er, (n % 5) == 0, "random");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule